// File: doc/BRIEF.md
# Bus Address-Error Response Controller

This block sits beside a bus target interface and decides how a transaction with an uncorrectable address or attribute error is handled. The target logic raises a one-cycle error strobe for each such transaction, together with the current bus mode and the address and attribute values of that transaction. Control bits from elsewhere in the register file select the response. In conventional mode with error response enabled, the transaction is dropped by suppressing device-select, so the initiator ends it with a master-abort. In either split-transaction mode with error response enabled, the bus side completes as usual but the request or completion is held back from the internal fabric. With error response disabled, the transaction runs unchanged.

Independently of the response, the block records the event in sticky write-1-to-clear status bits. It keeps a separate set of interrupt-status bits, each gated by its own mask or enable, and drives one combined interrupt request. When both the system-error enable and the error-response enable are set, it emits a one-cycle active-low system-error pulse. In the second-generation split mode it also latches the failing transaction's two address phases and its attribute into a log that holds its contents until software frees it.

Top module: `addr_err_resp`

## Requirements
- R1: With `bus_mode` = 2'b00 (conventional) and `perr_resp_en` = 1, `devsel_block` is 1 and `fwd_inhibit` is 0 in the same cycle as `err_strobe`.
- R2: With `bus_mode` = 2'b01, 2'b10 or 2'b11 (split modes) and `perr_resp_en` = 1, `fwd_inhibit` is 1 and `devsel_block` is 0 in the same cycle as `err_strobe`.
- R3: With `perr_resp_en` = 0, `devsel_block` and `fwd_inhibit` stay 0 whatever the error strobe, and the status bits are still recorded.
- R4: `serr_n` is 0 for exactly the one cycle after an `err_strobe` cycle in which `serr_en` and `perr_resp_en` were both 1. At all other times it is 1.
- R5: When `serr_n` pulses, status bit 0 (register index 0) is set. Interrupt-status bit 0 (index 1) is also set unless `serr_irq_mask` is 1.
- R6: When `serr_n` pulses with `serr_det_ie` = 1, interrupt-status bit 1 is set. Without a pulse, or with `serr_det_ie` = 0, it is not set.
- R7: Every error strobe sets status bit 1 (address/attribute error) and status bit 2 (detected parity error) in the next cycle.
- R8: Every error strobe sets interrupt-status bit 2 unless `perr_irq_mask` is 1.
- R9: Only when `bus_mode` = 2'b10 does an error capture `err_addr_lo`, `err_addr_hi` and `err_attr` into indices 3, 4 and 5 and set the log-valid bit 0 of index 2. Errors in other modes leave index 2 unchanged.
- R10: While log-valid is 1, a further capture-mode error keeps the logged values and sets bit 1 (missed) of index 2. Writing 1 to bit 0 of index 2 clears both bits.
- R11: Status and interrupt-status bits are sticky and cleared only by writing 1 to them. A write-1-to-clear and a new set in the same cycle leave the bit set.
- R12: `irq` is 1 exactly when any interrupt-status bit is 1.
- R13: After reset all status, interrupt-status and log-control bits read 0, `serr_n` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | 00 conventional, 01 split, 10 split second generation, 11 split |
| err_strobe | input | 1 | One cycle per transaction with an uncorrectable address/attribute error |
| err_addr_lo | input | ADDR_W | First address phase of the failing transaction |
| err_addr_hi | input | ADDR_W | Second address phase of the failing transaction |
| err_attr | input | ATTR_W | Attribute of the failing transaction |
| perr_resp_en | input | 1 | Error-response enable |
| serr_en | input | 1 | System-error output enable |
| serr_det_ie | input | 1 | Enable for the system-error detected interrupt-status bit |
| serr_irq_mask | input | 1 | Mask for the system-error asserted interrupt-status bit |
| perr_irq_mask | input | 1 | Mask for the parity-error interrupt-status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DATA_W | Write data (1 bits clear) |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| devsel_block | output | 1 | Suppress device-select for this transaction |
| fwd_inhibit | output | 1 | Do not forward this transaction to the internal fabric |
| serr_n | output | 1 | Active-low system-error pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong response decision shows on `devsel_block` or `fwd_inhibit` in the same cycle as the strobe. A wrong flag, mask or enable path shows one cycle later on `serr_n`, on `irq`, or in the status words read at indices 0 and 1. Loss of stickiness or a wrong clear priority shows at the first read after the colliding write. Log corruption shows only when indices 2 to 5 are read after a second error, so the directed log test reads them right after each error.

// File: rtl/aerc_pkg.sv
package aerc_pkg;

    typedef enum logic [1:0] {
        MODE_CONV   = 2'b00,
        MODE_SPLIT  = 2'b01,
        MODE_SPLIT2 = 2'b10,
        MODE_SPLITX = 2'b11
    } bus_mode_e;

    localparam int NFLAG = 3;

    // status bit positions
    localparam int ST_SERR = 0;
    localparam int ST_ADDR = 1;
    localparam int ST_PAR  = 2;

    // interrupt-status bit positions
    localparam int IS_SERR_ASRT = 0;
    localparam int IS_SERR_DET  = 1;
    localparam int IS_PAR       = 2;

    // register indices
    localparam logic [2:0] RI_STAT   = 3'd0;
    localparam logic [2:0] RI_INT    = 3'd1;
    localparam logic [2:0] RI_LOGCTL = 3'd2;
    localparam logic [2:0] RI_LOGA1  = 3'd3;
    localparam logic [2:0] RI_LOGA2  = 3'd4;
    localparam logic [2:0] RI_LOGAT  = 3'd5;

    // log-control bit positions
    localparam int LC_VALID  = 0;
    localparam int LC_MISSED = 1;

endpackage

// File: rtl/aerc_decide.sv
module aerc_decide
    import aerc_pkg::*;
(
    input  logic       err_strobe,
    input  logic [1:0] bus_mode,
    input  logic       perr_resp_en,
    input  logic       serr_en,
    output logic       devsel_block,
    output logic       fwd_inhibit,
    output logic       serr_fire,
    output logic       log_capture
);

    logic is_conv;
    logic respond;

    always_comb begin
        is_conv      = (bus_mode == MODE_CONV);
        respond      = err_strobe && perr_resp_en;
        devsel_block = respond && is_conv;
        fwd_inhibit  = respond && !is_conv;
        serr_fire    = respond && serr_en;
        log_capture  = err_strobe && (bus_mode == MODE_SPLIT2);
    end

endmodule

// File: rtl/aerc_flags.sv
module aerc_flags
    import aerc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_strobe,
    input  logic             serr_fire,
    input  logic             serr_det_ie,
    input  logic             serr_irq_mask,
    input  logic             perr_irq_mask,
    input  logic [NFLAG-1:0] clr_stat,
    input  logic [NFLAG-1:0] clr_int,
    output logic [NFLAG-1:0] stat_q,
    output logic [NFLAG-1:0] int_q,
    output logic             serr_n
);

    typedef struct packed {
        logic [NFLAG-1:0] stat;
        logic [NFLAG-1:0] intr;
        logic             serr;
    } flag_t;

    flag_t st_d, st_q;
    logic [NFLAG-1:0] stat_set;
    logic [NFLAG-1:0] int_set;

    always_comb begin
        stat_set               = '0;
        stat_set[ST_SERR]      = serr_fire;
        stat_set[ST_ADDR]      = err_strobe;
        stat_set[ST_PAR]       = err_strobe;

        int_set                = '0;
        int_set[IS_SERR_ASRT]  = serr_fire && !serr_irq_mask;
        int_set[IS_SERR_DET]   = serr_fire && serr_det_ie;
        int_set[IS_PAR]        = err_strobe && !perr_irq_mask;

        st_d = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            // a set in the same cycle as a clear wins
            st_d.stat[i] = (st_q.stat[i] && !clr_stat[i]) || stat_set[i];
            st_d.intr[i] = (st_q.intr[i] && !clr_int[i])  || int_set[i];
        end
        st_d.serr = serr_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;
    assign int_q  = st_q.intr;
    assign serr_n = !st_q.serr;

endmodule

// File: rtl/aerc_log.sv
module aerc_log #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [ATTR_W-1:0] attr,
    output logic              valid,
    output logic              missed,
    output logic [ADDR_W-1:0] first_q,
    output logic [ADDR_W-1:0] second_q,
    output logic [ATTR_W-1:0] attr_q
);

    typedef struct packed {
        logic              valid;
        logic              missed;
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] second;
        logic [ATTR_W-1:0] attr;
    } log_t;

    log_t lg_d, lg_q;
    logic free;

    always_comb begin
        lg_d = lg_q;
        free = !lg_q.valid || clear;
        if (clear) begin
            lg_d.valid  = 1'b0;
            lg_d.missed = 1'b0;
        end
        if (capture) begin
            if (free) begin
                lg_d.first  = addr_lo;
                lg_d.second = addr_hi;
                lg_d.attr   = attr;
                lg_d.valid  = 1'b1;
            end else begin
                lg_d.missed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lg_q <= '0;
        else        lg_q <= lg_d;
    end

    assign valid    = lg_q.valid;
    assign missed   = lg_q.missed;
    assign first_q  = lg_q.first;
    assign second_q = lg_q.second;
    assign attr_q   = lg_q.attr;

endmodule

// File: rtl/addr_err_resp.sv
module addr_err_resp
    import aerc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic              err_strobe,
    input  logic [ADDR_W-1:0] err_addr_lo,
    input  logic [ADDR_W-1:0] err_addr_hi,
    input  logic [ATTR_W-1:0] err_attr,
    input  logic              perr_resp_en,
    input  logic              serr_en,
    input  logic              serr_det_ie,
    input  logic              serr_irq_mask,
    input  logic              perr_irq_mask,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              devsel_block,
    output logic              fwd_inhibit,
    output logic              serr_n,
    output logic              irq
);

    logic             serr_fire;
    logic             log_capture;
    logic             log_clear;
    logic [NFLAG-1:0] clr_stat;
    logic [NFLAG-1:0] clr_int;
    logic [NFLAG-1:0] stat_q;
    logic [NFLAG-1:0] int_q;
    logic             log_valid;
    logic             log_missed;
    logic [ADDR_W-1:0] log_first;
    logic [ADDR_W-1:0] log_second;
    logic [ATTR_W-1:0] log_attr;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:NFLAG];

    aerc_decide u_decide (
        .err_strobe   (err_strobe),
        .bus_mode     (bus_mode),
        .perr_resp_en (perr_resp_en),
        .serr_en      (serr_en),
        .devsel_block (devsel_block),
        .fwd_inhibit  (fwd_inhibit),
        .serr_fire    (serr_fire),
        .log_capture  (log_capture)
    );

    always_comb begin
        clr_stat  = (reg_wr && reg_addr == RI_STAT) ? reg_wdata[NFLAG-1:0] : '0;
        clr_int   = (reg_wr && reg_addr == RI_INT)  ? reg_wdata[NFLAG-1:0] : '0;
        log_clear = reg_wr && (reg_addr == RI_LOGCTL) && reg_wdata[LC_VALID];
    end

    aerc_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_strobe    (err_strobe),
        .serr_fire     (serr_fire),
        .serr_det_ie   (serr_det_ie),
        .serr_irq_mask (serr_irq_mask),
        .perr_irq_mask (perr_irq_mask),
        .clr_stat      (clr_stat),
        .clr_int       (clr_int),
        .stat_q        (stat_q),
        .int_q         (int_q),
        .serr_n        (serr_n)
    );

    aerc_log #(
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W)
    ) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (log_capture),
        .clear    (log_clear),
        .addr_lo  (err_addr_lo),
        .addr_hi  (err_addr_hi),
        .attr     (err_attr),
        .valid    (log_valid),
        .missed   (log_missed),
        .first_q  (log_first),
        .second_q (log_second),
        .attr_q   (log_attr)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_STAT:   reg_rdata[NFLAG-1:0] = stat_q;
            RI_INT:    reg_rdata[NFLAG-1:0] = int_q;
            RI_LOGCTL: begin
                reg_rdata[LC_VALID]  = log_valid;
                reg_rdata[LC_MISSED] = log_missed;
            end
            RI_LOGA1:  reg_rdata = DATA_W'(log_first);
            RI_LOGA2:  reg_rdata = DATA_W'(log_second);
            RI_LOGAT:  reg_rdata = DATA_W'(log_attr);
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |int_q;

endmodule

// File: rtl/aerc_chk.sv
module aerc_chk
    import aerc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_mode,
    input logic              err_strobe,
    input logic              perr_resp_en,
    input logic              serr_en,
    input logic              devsel_block,
    input logic              fwd_inhibit,
    input logic              serr_n,
    input logic              irq,
    input logic [NFLAG-1:0]  stat_q,
    input logic              log_valid,
    input logic              log_clear,
    input logic [ADDR_W-1:0] log_first
);

    // R1
    conv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe && perr_resp_en && bus_mode == MODE_CONV |-> devsel_block && !fwd_inhibit);

    // R2
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe && perr_resp_en && bus_mode != MODE_CONV |-> fwd_inhibit && !devsel_block);

    // R3
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_resp_en |-> !devsel_block && !fwd_inhibit);

    // R4
    serr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe && perr_resp_en && serr_en |=> !serr_n);

    // R4
    serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(err_strobe && perr_resp_en && serr_en));

    // R7
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |=> stat_q[ST_ADDR] && stat_q[ST_PAR]);

    // R10
    log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid && !log_clear |=> $stable(log_first) && log_valid);

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(err_strobe));

endmodule

bind addr_err_resp aerc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_mode     (bus_mode),
    .err_strobe   (err_strobe),
    .perr_resp_en (perr_resp_en),
    .serr_en      (serr_en),
    .devsel_block (devsel_block),
    .fwd_inhibit  (fwd_inhibit),
    .serr_n       (serr_n),
    .irq          (irq),
    .stat_q       (stat_q),
    .log_valid    (log_valid),
    .log_clear    (log_clear),
    .log_first    (log_first)
);

// File: tb/addr_err_resp_tb.sv
`timescale 1ns/100ps
module addr_err_resp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'b00;
    logic        err_strobe = 1'b0;
    logic [31:0] err_addr_lo = '0;
    logic [31:0] err_addr_hi = '0;
    logic [31:0] err_attr = '0;
    logic        perr_resp_en = 1'b0;
    logic        serr_en = 1'b0;
    logic        serr_det_ie = 1'b0;
    logic        serr_irq_mask = 1'b0;
    logic        perr_irq_mask = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        devsel_block;
    logic        fwd_inhibit;
    logic        serr_n;
    logic        irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_err_resp u_dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .err_strobe(err_strobe),
        .err_addr_lo(err_addr_lo), .err_addr_hi(err_addr_hi), .err_attr(err_attr),
        .perr_resp_en(perr_resp_en), .serr_en(serr_en), .serr_det_ie(serr_det_ie),
        .serr_irq_mask(serr_irq_mask), .perr_irq_mask(perr_irq_mask),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .devsel_block(devsel_block), .fwd_inhibit(fwd_inhibit), .serr_n(serr_n), .irq(irq)
    );

    // {mode[1:0], pre, se, ie, smask, pmask, exp_devsel, exp_fwd, exp_serr_low,
    //  exp_stat[2:0], exp_int[2:0]}
    localparam logic [15:0] VEC [8] = '{
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 3'b111},
        {2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110, 3'b100},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b110, 3'b100},
        {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 3'b100},
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 3'b011},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b110, 3'b000},
        {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 3'b101},
        {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b110, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic strobe(input logic [1:0] m, input logic pre,
                          input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] at);
        @(negedge clk);
        bus_mode = m; perr_resp_en = pre;
        err_addr_lo = a1; err_addr_hi = a2; err_attr = at;
        err_strobe = 1'b1;
        @(negedge clk);
        err_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        string tag;

        // R13 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        check("R13 serr_n", {31'd0, serr_n}, 32'd1);
        check("R13 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, v); check("R13 status", v, 32'd0);
        rd(3'd1, v); check("R13 int", v, 32'd0);
        rd(3'd2, v); check("R13 logctl", v, 32'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < 8; i++) begin
            logic [15:0] e;
            e = VEC[i];
            @(negedge clk);
            bus_mode = e[15:14]; perr_resp_en = e[13]; serr_en = e[12];
            serr_det_ie = e[11]; serr_irq_mask = e[10]; perr_irq_mask = e[9];
            err_addr_lo = 32'h1000 + i; err_addr_hi = 32'h2000 + i; err_attr = 32'h30 + i;
            err_strobe = 1'b1;
            #0.5;
            tag = (e[15:14] == 2'b00) ? "R1" : "R2";
            if (!e[13]) tag = "R3";
            check({tag, " devsel_block"}, {31'd0, devsel_block}, {31'd0, e[8]});
            check({tag, " fwd_inhibit"}, {31'd0, fwd_inhibit}, {31'd0, e[7]});
            @(negedge clk);
            err_strobe = 1'b0;
            #0.5;
            check("R4 serr_n pulse", {31'd0, serr_n}, {31'd0, ~e[6]});
            rd(3'd0, v); check("R5 R7 status", v, {29'd0, e[5:3]});
            rd(3'd1, v); check("R6 R8 int", v, {29'd0, e[2:0]});
            check("R12 irq", {31'd0, irq}, {31'd0, |e[2:0]});
            @(negedge clk);
            #0.5;
            check("R4 serr_n single", {31'd0, serr_n}, 32'd1);
            clear_all();
            #0.5;
            check("R11 cleared irq", {31'd0, irq}, 32'd0);
            rd(3'd0, v); check("R11 cleared status", v, 32'd0);
        end

        // R11 set wins over clear in the same cycle
        serr_en = 1'b0; perr_irq_mask = 1'b0; serr_det_ie = 1'b0;
        @(negedge clk);
        bus_mode = 2'b00; perr_resp_en = 1'b0; err_strobe = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        err_strobe = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        #0.5;
        rd(3'd0, v); check("R11 set wins", v, 32'd6);
        // R11 partial clear of bit 1 only
        wr(3'd0, 32'd2);
        #0.5;
        rd(3'd0, v); check("R11 partial clear", v, 32'd4);
        // R12 irq drops when last interrupt bit cleared
        check("R12 irq held", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'd4);
        #0.5;
        check("R12 irq cleared", {31'd0, irq}, 32'd0);
        clear_all();

        // R9 capture in second-generation split mode
        strobe(2'b10, 1'b1, 32'hA1A1_0001, 32'hA2A2_0002, 32'h0000_0AB5);
        #0.5;
        rd(3'd2, v); check("R9 log valid", v, 32'd1);
        rd(3'd3, v); check("R9 log first", v, 32'hA1A1_0001);
        rd(3'd4, v); check("R9 log second", v, 32'hA2A2_0002);
        rd(3'd5, v); check("R9 log attr", v, 32'h0000_0AB5);
        // R10 second error while valid: values held, missed set
        strobe(2'b10, 1'b0, 32'hBEEF_0001, 32'hBEEF_0002, 32'h0000_0FFF);
        #0.5;
        rd(3'd2, v); check("R10 missed", v, 32'd3);
        rd(3'd3, v); check("R10 first held", v, 32'hA1A1_0001);
        rd(3'd5, v); check("R10 attr held", v, 32'h0000_0AB5);
        wr(3'd2, 32'd1);
        #0.5;
        rd(3'd2, v); check("R10 log freed", v, 32'd0);
        // R9 other modes do not capture
        strobe(2'b01, 1'b1, 32'h5555_0001, 32'h5555_0002, 32'h0000_0111);
        strobe(2'b00, 1'b1, 32'h6666_0001, 32'h6666_0002, 32'h0000_0222);
        #0.5;
        rd(3'd2, v); check("R9 no capture", v, 32'd0);
        // R9 capture after freeing takes the new values
        strobe(2'b10, 1'b0, 32'h7777_0001, 32'h7777_0002, 32'h0000_0333);
        #0.5;
        rd(3'd3, v); check("R9 recapture", v, 32'h7777_0001);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule